// File: doc/BRIEF.md
# Stack and Relative Branch Unit

This unit carries out the near stack and relative control-transfer operations of a 64-bit core: push, pop, call, return, frame leave, unconditional short jump and short jump-if-not-sign. It owns the stack pointer, the frame pointer and the instruction pointer, and updates them in the order that the operations define. It reads and writes a byte-addressed data memory one 64-bit word at a time through a request/ready port.

A decoder presents an operation code, the operand kind and size, a push value, a displacement and the current sign flag, together with a one-cycle start strobe. While the unit is busy it ignores further strobes. At the end of a legal operation it gives a one-cycle done pulse. An illegal operand combination gives a one-cycle error pulse instead, and then no register changes and no memory access is made. For a pop, the word that was read is presented on a result port.

Top module: `stack_branch_unit`

## Requirements
- R1: During and after reset, the stack pointer, frame pointer and instruction pointer hold their reset parameter values, and done, err and mem_req are 0.
- R2: PUSH (op 0) first lowers the stack pointer by 8. It then writes the value at the new stack pointer, sign-extended from the operand size. Size codes are 0=8, 1=16, 2=32 and 3=64 bits.
- R3: POP (op 1) reads the word at the stack pointer, presents it on pop_data and then raises the stack pointer by 8.
- R4: CALL (op 2) lowers the stack pointer by 8 and stores the old instruction pointer there. It then adds the sign-extended 32-bit displacement to the instruction pointer.
- R5: RET (op 3) loads the instruction pointer from the word at the stack pointer, then raises the stack pointer by 8.
- R6: LEAVE (op 4) copies the frame pointer into the stack pointer, loads the frame pointer from the word at that address, then raises the stack pointer by 8.
- R7: JMP short (op 5) adds disp[7:0], sign-extended, to the instruction pointer, with no memory access.
- R8: JNS short (op 6) adds disp[7:0], sign-extended, to the instruction pointer when sf is 0. When sf is 1 the instruction pointer is unchanged.
- R9: Some operations are illegal. These are a PUSH with an 8-bit register or memory source, a PUSH with a 64-bit immediate, a POP of any size other than 64, and op 7. Source kind codes are 0=immediate, 1=register and 2=memory. An illegal operation pulses err for one cycle, issues no memory request, gives no done pulse and changes no register.
- R10: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata steady until the cycle in which mem_ready is 1.
- R11: done is high for exactly one cycle after the last register update, and a start strobe seen while the unit is busy has no effect.
- R12: Memory words are little-endian: mem_wdata/mem_rdata bits [8i+7:8i] belong to byte address mem_addr+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 3 | Operation code |
| src_kind | input | 2 | PUSH source kind (0 imm, 1 reg, 2 mem) |
| src_size | input | 2 | Operand size code (0=8,1=16,2=32,3=64) |
| push_value | input | 64 | PUSH value, low bits meaningful per size |
| disp | input | 32 | Displacement (8-bit forms use bits 7:0) |
| sf | input | 1 | Current sign flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 64 | Write word, little-endian |
| mem_ready | input | 1 | Memory accepts / completes the request |
| mem_rdata | input | 64 | Read word, valid when mem_ready |
| rsp | output | 64 | Stack pointer |
| rbp | output | 64 | Frame pointer |
| rip | output | 64 | Instruction pointer |
| pop_data | output | 64 | Last popped word |
| done | output | 1 | Operation completed pulse |
| err | output | 1 | Illegal operation pulse |

## Verification
Two situations are hard to reach from the ports. One is a start strobe that arrives while a memory access is stalled. The bench reaches it by giving the memory model a long ready latency and pulsing a jump strobe during the stall; the instruction pointer must then show no trace of that jump. The other is the ordering inside LEAVE, where the read address must be the old frame pointer and not the stack pointer. The bench sets these two apart by moving the stack pointer well away from the frame pointer with earlier pushes, and it fills memory with a byte pattern that depends on the address, so a read from the wrong address gives a visibly wrong word.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int unsigned WORD_W     = 64;
    localparam int unsigned WORD_BYTES = WORD_W / 8;
    localparam int unsigned DISP_W     = 32;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_LEAVE = 3'd4,
        OP_JMP   = 3'd5,
        OP_JNS   = 3'd6,
        OP_RSVD  = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_REG = 2'd1,
        SRC_MEM = 2'd2,
        SRC_XX  = 2'd3
    } src_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DONE,
        ST_ERR
    } stk_state_e;

    typedef struct packed {
        logic rsp_dec;
        logic rsp_inc;
        logic rsp_from_rbp;
        logic rip_branch;
        logic rip_load;
        logic rbp_load;
        logic pop_load;
    } upd_t;

    function automatic logic [WORD_W-1:0] sext_by_size(input logic [WORD_W-1:0] v,
                                                       input logic [1:0] sz);
        logic [WORD_W-1:0] r;
        case (sz)
            2'd0:    r = {{(WORD_W-8){v[7]}}, v[7:0]};
            2'd1:    r = {{(WORD_W-16){v[15]}}, v[15:0]};
            2'd2:    r = {{(WORD_W-32){v[31]}}, v[31:0]};
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic push_ok(input src_kind_e kind, input logic [1:0] sz);
        logic narrow_rm, wide_imm;
        narrow_rm = (kind != SRC_IMM) && (sz == 2'd0);
        wide_imm  = (kind == SRC_IMM) && (sz == 2'd3);
        return !(narrow_rm || wide_imm);
    endfunction
endpackage

// File: rtl/stk_arith.sv
module stk_arith
    import stk_pkg::*;
#(
    parameter int unsigned W     = WORD_W,
    parameter int unsigned STEP  = WORD_BYTES,
    parameter int unsigned DW    = DISP_W
) (
    input  logic [W-1:0]  rsp_in,
    input  logic [W-1:0]  rip_in,
    input  logic [DW-1:0] disp_in,
    input  logic          long_disp,
    output logic [W-1:0]  rsp_dn,
    output logic [W-1:0]  rsp_up,
    output logic [W-1:0]  rip_tgt
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] disp_ext;

    always_comb begin
        if (long_disp)
            disp_ext = {{(W-DW){disp_in[DW-1]}}, disp_in};
        else
            disp_ext = {{(W-8){disp_in[7]}}, disp_in[7:0]};
    end

    assign rsp_dn  = rsp_in - STEP_V;
    assign rsp_up  = rsp_in + STEP_V;
    assign rip_tgt = rip_in + disp_ext;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] op,
    input  logic [1:0] src_kind,
    input  logic [1:0] src_size,
    input  logic       sf,
    input  logic       mem_ready,
    output stk_op_e    op_q,
    output logic       accept,
    output upd_t       upd,
    output logic       in_idle,
    output logic       mem_req,
    output logic       mem_we,
    output logic       done,
    output logic       err
);
    stk_state_e state, nxt;
    stk_op_e    op_in;

    assign op_in = stk_op_e'(op);

    always_comb begin
        nxt    = state;
        upd    = '0;
        accept = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                accept = 1'b1;
                case (op_in)
                    OP_PUSH: if (push_ok(src_kind_e'(src_kind), src_size)) begin
                        upd.rsp_dec = 1'b1;
                        nxt = ST_WRITE;
                    end else nxt = ST_ERR;
                    OP_CALL: begin
                        upd.rsp_dec = 1'b1;
                        nxt = ST_WRITE;
                    end
                    OP_POP:   nxt = (src_size == 2'd3) ? ST_READ : ST_ERR;
                    OP_RET:   nxt = ST_READ;
                    OP_LEAVE: begin
                        upd.rsp_from_rbp = 1'b1;
                        nxt = ST_READ;
                    end
                    OP_JMP: begin
                        upd.rip_branch = 1'b1;
                        nxt = ST_DONE;
                    end
                    OP_JNS: begin
                        upd.rip_branch = !sf;
                        nxt = ST_DONE;
                    end
                    default: nxt = ST_ERR;
                endcase
            end
            ST_WRITE: if (mem_ready) begin
                upd.rip_branch = (op_q == OP_CALL);
                nxt = ST_DONE;
            end
            ST_READ: if (mem_ready) begin
                upd.rsp_inc  = 1'b1;
                upd.pop_load = (op_q == OP_POP);
                upd.rip_load = (op_q == OP_RET);
                upd.rbp_load = (op_q == OP_LEAVE);
                nxt = ST_DONE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= OP_PUSH;
        end else begin
            state <= nxt;
            if (accept) op_q <= op_in;
        end
    end

    assign in_idle = (state == ST_IDLE);
    assign mem_req = (state == ST_WRITE) || (state == ST_READ);
    assign mem_we  = (state == ST_WRITE);
    assign done    = (state == ST_DONE);
    assign err     = (state == ST_ERR);

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: an error cycle never overlaps a memory request and never follows one
    p_err_no_mem_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_req && !$past(mem_req));
endmodule

// File: rtl/stack_branch_unit.sv
module stack_branch_unit
    import stk_pkg::*;
#(
    parameter logic [WORD_W-1:0] RSP_RESET = 64'h0000_0000_0000_0080,
    parameter logic [WORD_W-1:0] RBP_RESET = 64'h0000_0000_0000_0040,
    parameter logic [WORD_W-1:0] RIP_RESET = 64'h0000_0000_0000_1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          op,
    input  logic [1:0]          src_kind,
    input  logic [1:0]          src_size,
    input  logic [WORD_W-1:0]   push_value,
    input  logic [DISP_W-1:0]   disp,
    input  logic                sf,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [WORD_W-1:0]   rsp,
    output logic [WORD_W-1:0]   rbp,
    output logic [WORD_W-1:0]   rip,
    output logic [WORD_W-1:0]   pop_data,
    output logic                done,
    output logic                err
);
    logic [WORD_W-1:0] rsp_q, rbp_q, rip_q, pop_q, wdata_q;
    logic [DISP_W-1:0] disp_q, disp_cur;
    logic [WORD_W-1:0] rsp_dn, rsp_up, rip_tgt;
    stk_op_e           op_q;
    upd_t              upd;
    logic              accept, in_idle, long_disp;

    stk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .src_kind  (src_kind),
        .src_size  (src_size),
        .sf        (sf),
        .mem_ready (mem_ready),
        .op_q      (op_q),
        .accept    (accept),
        .upd       (upd),
        .in_idle   (in_idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .done      (done),
        .err       (err)
    );

    assign disp_cur  = in_idle ? disp : disp_q;
    assign long_disp = in_idle ? (stk_op_e'(op) == OP_CALL) : (op_q == OP_CALL);

    stk_arith #(.W(WORD_W), .STEP(WORD_BYTES), .DW(DISP_W)) u_arith (
        .rsp_in    (rsp_q),
        .rip_in    (rip_q),
        .disp_in   (disp_cur),
        .long_disp (long_disp),
        .rsp_dn    (rsp_dn),
        .rsp_up    (rsp_up),
        .rip_tgt   (rip_tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q   <= RSP_RESET;
            rbp_q   <= RBP_RESET;
            rip_q   <= RIP_RESET;
            pop_q   <= '0;
            wdata_q <= '0;
            disp_q  <= '0;
        end else begin
            if (accept) begin
                disp_q  <= disp;
                wdata_q <= (stk_op_e'(op) == OP_CALL) ? rip_q
                                                      : sext_by_size(push_value, src_size);
            end
            if (upd.rsp_dec)           rsp_q <= rsp_dn;
            else if (upd.rsp_inc)      rsp_q <= rsp_up;
            else if (upd.rsp_from_rbp) rsp_q <= rbp_q;
            if (upd.rip_branch)        rip_q <= rip_tgt;
            else if (upd.rip_load)     rip_q <= mem_rdata;
            if (upd.rbp_load)          rbp_q <= mem_rdata;
            if (upd.pop_load)          pop_q <= mem_rdata;
        end
    end

    assign mem_addr  = rsp_q;
    assign mem_wdata = wdata_q;
    assign rsp       = rsp_q;
    assign rbp       = rbp_q;
    assign rip       = rip_q;
    assign pop_data  = pop_q;

    // R10: a stalled request is held unchanged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                                  && $stable(mem_wdata));

    // R2: a write request starts only after the pointer has moved down by one word
    p_dec_before_write_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && mem_we |-> rsp_q == $past(rsp_q) - WORD_W'(WORD_BYTES));

    // R9: the error cycle leaves every architectural register alone
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(rsp_q) && $stable(rbp_q) && $stable(rip_q));

    // R3: the pointer moves up only on the cycle a read completes
    p_inc_on_read_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ready |=> rsp_q == $past(rsp_q) + WORD_W'(WORD_BYTES));
endmodule

// File: tb/test_stack_branch_unit.sv
module test_stack_branch_unit;
    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  kind;
        logic [1:0]  size;
        logic [63:0] value;
        logic [31:0] disp;
        logic        sf;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 2'd2, 64'h0000_0000_FFFF_FF00, 32'h0, 1'b0, 4'd0}, // push imm32 negative
        '{3'd0, 2'd1, 2'd1, 64'h0000_0000_0000_1234, 32'h0, 1'b0, 4'd2}, // push reg16
        '{3'd1, 2'd1, 2'd3, 64'h0,                   32'h0, 1'b0, 4'd1}, // pop 64
        '{3'd0, 2'd1, 2'd0, 64'h55,                  32'h0, 1'b0, 4'd0}, // push reg8 illegal
        '{3'd0, 2'd0, 2'd3, 64'h77,                  32'h0, 1'b0, 4'd0}, // push imm64 illegal
        '{3'd1, 2'd1, 2'd2, 64'h0,                   32'h0, 1'b0, 4'd0}, // pop 32 illegal
        '{3'd2, 2'd0, 2'd0, 64'h0,           32'hFFFF_FFF0, 1'b0, 4'd3}, // call -16
        '{3'd3, 2'd0, 2'd0, 64'h0,                   32'h0, 1'b0, 4'd0}, // ret
        '{3'd5, 2'd0, 2'd0, 64'h0,           32'h0000_007F, 1'b0, 4'd0}, // jmp +127
        '{3'd5, 2'd0, 2'd0, 64'h0,           32'h0000_0080, 1'b0, 4'd0}, // jmp -128
        '{3'd6, 2'd0, 2'd0, 64'h0,           32'h0000_0010, 1'b1, 4'd0}, // jns sf=1
        '{3'd6, 2'd0, 2'd0, 64'h0,           32'h0000_0010, 1'b0, 4'd0}, // jns sf=0
        '{3'd0, 2'd0, 2'd0, 64'h0000_0000_0000_0080, 32'h0, 1'b0, 4'd0}, // push imm8
        '{3'd4, 2'd0, 2'd0, 64'h0,                   32'h0, 1'b0, 4'd1}, // leave
        '{3'd0, 2'd2, 2'd3, 64'h0102_0304_0506_0708, 32'h0, 1'b0, 4'd2}, // push mem64
        '{3'd7, 2'd0, 2'd0, 64'h0,                   32'h0, 1'b0, 4'd0}  // reserved op
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic [1:0]  src_kind, src_size;
    logic [63:0] push_value;
    logic [31:0] disp;
    logic        sf;
    logic        mem_req, mem_we, mem_ready;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [63:0] rsp, rbp, rip, pop_data;
    logic        done, err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [3:0] cur_lat = 4'd0;
    logic [3:0] wcnt;
    logic [7:0] mem_b [256];
    logic [7:0] mdl_b [256];
    logic [63:0] m_rsp, m_rbp, m_rip, m_pop;

    always #5 clk = ~clk;

    stack_branch_unit i_stack_branch_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .src_kind(src_kind),
        .src_size(src_size), .push_value(push_value), .disp(disp), .sf(sf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .rsp(rsp), .rbp(rbp), .rip(rip),
        .pop_data(pop_data), .done(done), .err(err)
    );

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a * 7) ^ 8'hA5;
    endfunction

    // memory model, little-endian per R12
    assign mem_ready = mem_req && (wcnt >= cur_lat);
    always_comb begin
        for (int i = 0; i < 8; i++)
            mem_rdata[8*i +: 8] = mem_b[8'(mem_addr[7:0] + 8'(i))];
    end
    always @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
            for (int a = 0; a < 256; a++) mem_b[a] <= init_byte(a);
        end else if (mem_req && mem_ready) begin
            wcnt <= '0;
            if (mem_we)
                for (int i = 0; i < 8; i++)
                    mem_b[8'(mem_addr[7:0] + 8'(i))] <= mem_wdata[8*i +: 8];
        end else if (mem_req) begin
            wcnt <= wcnt + 4'd1;
        end
    end

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mdl_rd(input logic [63:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[8*i +: 8] = mdl_b[8'(a[7:0] + 8'(i))];
        return w;
    endfunction

    task automatic mdl_wr(input logic [63:0] a, input logic [63:0] w);
        for (int i = 0; i < 8; i++) mdl_b[8'(a[7:0] + 8'(i))] = w[8*i +: 8];
    endtask

    function automatic logic [63:0] tb_rd(input logic [63:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[8*i +: 8] = mem_b[8'(a[7:0] + 8'(i))];
        return w;
    endfunction

    function automatic logic [63:0] ext(input logic [63:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return {{56{v[7]}}, v[7:0]};
            2'd1:    return {{48{v[15]}}, v[15:0]};
            2'd2:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic legal(input vec_t v);
        case (v.op)
            3'd0:    return !((v.kind != 2'd0 && v.size == 2'd0) || (v.kind == 2'd0 && v.size == 2'd3));
            3'd1:    return v.size == 2'd3;
            3'd7:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // reference model of the requirements R2..R8
    task automatic model(input vec_t v);
        if (!legal(v)) return;
        case (v.op)
            3'd0: begin m_rsp = m_rsp - 64'd8; mdl_wr(m_rsp, ext(v.value, v.size)); end
            3'd1: begin m_pop = mdl_rd(m_rsp); m_rsp = m_rsp + 64'd8; end
            3'd2: begin
                m_rsp = m_rsp - 64'd8; mdl_wr(m_rsp, m_rip);
                m_rip = m_rip + {{32{v.disp[31]}}, v.disp};
            end
            3'd3: begin m_rip = mdl_rd(m_rsp); m_rsp = m_rsp + 64'd8; end
            3'd4: begin m_rsp = m_rbp; m_rbp = mdl_rd(m_rsp); m_rsp = m_rsp + 64'd8; end
            3'd5: m_rip = m_rip + {{56{v.disp[7]}}, v.disp[7:0]};
            3'd6: if (!v.sf) m_rip = m_rip + {{56{v.disp[7]}}, v.disp[7:0]};
            default: ;
        endcase
    endtask

    // issue one op; returns whether done/err was seen, a memory request was seen,
    // and whether a stalled request changed
    task automatic run_op(input vec_t v, input logic poke_busy,
                          output logic got_done, output logic got_err,
                          output logic saw_req, output logic hold_bad);
        logic [63:0] pa;
        logic        pw, pending;
        int n;
        got_done = 0; got_err = 0; saw_req = 0; hold_bad = 0; pending = 0;
        pa = '0; pw = 0;
        @(negedge clk);
        cur_lat = v.lat; op = v.op; src_kind = v.kind; src_size = v.size;
        push_value = v.value; disp = v.disp; sf = v.sf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && !err && n < 200) begin
            if (mem_req) begin
                saw_req = 1;
                if (pending && (mem_addr !== pa || mem_we !== pw)) hold_bad = 1;
                pending = !mem_ready; pa = mem_addr; pw = mem_we;
                if (poke_busy && n == 1) begin
                    op = 3'd5; disp = 32'h0000_0040; start = 1'b1;
                end else start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        got_done = done; got_err = err;
        if (n >= 200) begin
            fails = fails + 1;
            $display("FAIL R11: actual no done/err after %0d cycles, expected completion", n);
        end
        @(negedge clk);
        chk("R11 done one cycle", {63'd0, done}, 64'd0);
    endtask

    initial begin
        logic gd, ge, sr, hb;
        rst = 1'b1; start = 1'b0; op = '0; src_kind = '0; src_size = '0;
        push_value = '0; disp = '0; sf = 1'b0;
        for (int a = 0; a < 256; a++) mdl_b[a] = init_byte(a);
        m_rsp = 64'h80; m_rbp = 64'h40; m_rip = 64'h1000; m_pop = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rsp reset", rsp, 64'h80);
        chk("R1 rbp reset", rbp, 64'h40);
        chk("R1 rip reset", rip, 64'h1000);
        chk("R1 flags reset", {61'd0, done, err, mem_req}, 64'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VECS[k];
            run_op(v, 1'b0, gd, ge, sr, hb);
            model(v);
            if (!legal(v)) begin
                chk("R9 err pulse", {62'd0, ge, gd}, 64'd2);
                chk("R9 no memory request", {63'd0, sr}, 64'd0);
            end else begin
                chk("R11 done pulse", {62'd0, gd, ge}, 64'd2);
            end
            chk("R10 request held", {63'd0, hb}, 64'd0);
            chk("R2 R3 R4 R5 R6 rsp", rsp, m_rsp);
            chk("R6 rbp", rbp, m_rbp);
            chk("R4 R5 R7 R8 rip", rip, m_rip);
            chk("R3 pop_data", pop_data, m_pop);
            chk("R2 R4 stack word", tb_rd(m_rsp), mdl_rd(m_rsp));
            if (k == 14) chk("R12 low byte at lowest address", {56'd0, mem_b[rsp[7:0]]}, 64'h08);
            if (k == 14) chk("R12 high byte at top address", {56'd0, mem_b[8'(rsp[7:0] + 8'd7)]}, 64'h01);
        end

        // R11: start during a stalled push has no effect
        begin
            vec_t v;
            v = '{3'd0, 2'd0, 2'd1, 64'h0000_0000_0000_8001, 32'h0, 1'b0, 4'd6};
            run_op(v, 1'b1, gd, ge, sr, hb);
            model(v);
            chk("R11 busy start ignored rip", rip, m_rip);
            chk("R11 busy start rsp", rsp, m_rsp);
            chk("R2 sign-extended 16-bit push", tb_rd(rsp), 64'hFFFF_FFFF_FFFF_8001);
        end

        // R1: reset mid-sequence restores pointers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 rsp after reset", rsp, 64'h80);
        chk("R1 rip after reset", rip, 64'h1000);

        summary_and_end();
    end
endmodule